// File: doc/BRIEF.md
# Jitter Sampler with Parity Decimator

This block is the digital back end of a true random bit source built on two clocks whose frequencies stand in a fixed ratio KM/KD. The jittered clock is taken in as a plain data level and captured on every rising edge of the sampling clock. The captured level then passes through a short guard chain that limits metastability. The guarded samples are folded into a running exclusive-OR over exactly KD sampling cycles. KD sampling cycles is the length of one repeating beat of the two clocks.

At the end of each beat window the block presents the parity of that window on its bit output. It raises a one-cycle valid strobe alongside it and clears the accumulator for the next window. Without jitter every window sees the same sample pattern, so every bit is the same constant. Jitter moves only the few samples taken close to an edge of the jittered clock, and each such change inverts the bit of the window it falls in. KM and KD are parameters. Elaboration stops if they share a common factor or if KD is below 2.

Top module: `jitter_decimator`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `rnd_vld_o` is 0 and `rnd_bit_o` is 0.
- R2: `rnd_vld_o` is high for exactly one cycle in every KD cycles. The first strobe follows the KD-th rising edge after reset is released.
- R3: A level on `jit_clk_i` reaches the accumulator after 1+GUARD_STAGES sampling edges. The sampling and guard registers hold 0 during reset.
- R4: Each output bit is the XOR of the KD guarded samples that entered during its window. With no jitter, every bit from the second window on equals the parity of one full KD-sample pattern.
- R5: Inverting a single sampled level inverts the bit of the window that contains it, and no other bit.
- R6: The accumulator starts each window at 0, so no sample is counted in two windows.
- R7: The parameters must satisfy gcd(KM, KD) = 1 and KD >= 2, and GUARD_STAGES must be at least 1. Any other setting stops elaboration.
- R8: `rnd_bit_o` keeps its value in every cycle in which `rnd_vld_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_smp_i | input | 1 | Sampling clock; every register runs on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| jit_clk_i | input | 1 | Level of the jittered clock, sampled as data |
| rnd_bit_o | output | 1 | Parity of the most recently completed window |
| rnd_vld_o | output | 1 | One-cycle strobe marking a new `rnd_bit_o` |

## Verification
The wrap of the window counter and the arrival of a new guarded sample fall in the same cycle. In that cycle the last sample of a window must be folded into the emitted bit rather than into the next window. The bench provokes this by sweeping a single inverted sample across every position of a window, the last one included, on alternate windows. A bench model of the ratio's phase pattern then judges each bit as the constant pattern parity, inverted only for the window that holds the flip.

// File: rtl/jsd_pkg.sv
package jsd_pkg;

    // Greatest common divisor used by the elaboration checks.
    function automatic int unsigned jsd_gcd(int unsigned a_in, int unsigned b_in);
        int unsigned a;
        int unsigned b;
        int unsigned t;
        a = a_in;
        b = b_in;
        while (b != 0) begin
            t = a % b;
            a = b;
            b = t;
        end
        return a;
    endfunction

    // Width needed to count 0 .. n-1 (at least one bit).
    function automatic int unsigned jsd_cw(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/jsd_sampler.sv
module jsd_sampler #(
    parameter int unsigned GUARD_STAGES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic jit_i,
    output logic smp_o
);
    localparam int unsigned DEPTH = 1 + GUARD_STAGES;

    typedef struct packed {
        logic [DEPTH-1:0] pipe;
    } smp_st_t;

    smp_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pipe = {st_q.pipe[DEPTH-2:0], jit_i};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign smp_o = st_q.pipe[DEPTH-1];

    // R3
    guard_shift_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.pipe[1] == $past(st_q.pipe[0]));

endmodule

// File: rtl/jsd_window_ctr.sv
module jsd_window_ctr #(
    parameter int unsigned KD = 7
) (
    input  logic                          clk,
    input  logic                          rst,
    output logic [jsd_pkg::jsd_cw(KD)-1:0] cnt_o,
    output logic                          wrap_o
);
    localparam int unsigned CW = jsd_pkg::jsd_cw(KD);
    localparam logic [CW-1:0] LAST = CW'(KD - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ctr_st_t;

    ctr_st_t st_d, st_q;
    logic    at_end;

    always_comb begin
        st_d   = st_q;
        at_end = (st_q.cnt == LAST);
        if (at_end) st_d.cnt = '0;
        else        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign wrap_o = at_end;

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= LAST);

endmodule

// File: rtl/jsd_parity_acc.sv
module jsd_parity_acc (
    input  logic clk,
    input  logic rst,
    input  logic smp_i,
    input  logic wrap_i,
    output logic bit_o,
    output logic vld_o
);
    typedef struct packed {
        logic acc;
        logic rbit;
        logic vld;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic    folded;

    always_comb begin
        st_d   = st_q;
        folded = st_q.acc ^ smp_i;
        st_d.vld = wrap_i;
        if (wrap_i) begin
            st_d.rbit = folded;
            st_d.acc  = 1'b0;
        end else begin
            st_d.acc  = folded;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign bit_o = st_q.rbit;
    assign vld_o = st_q.vld;

    // R6
    acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_i |=> (st_q.acc == 1'b0));

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        vld_o |=> !vld_o);

    // R8
    bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !vld_o |-> $stable(bit_o));

endmodule

// File: rtl/jitter_decimator.sv
module jitter_decimator #(
    parameter int unsigned KM           = 5,
    parameter int unsigned KD           = 7,
    parameter int unsigned GUARD_STAGES = 1
) (
    input  logic clk_smp_i,
    input  logic rst_i,
    input  logic jit_clk_i,
    output logic rnd_bit_o,
    output logic rnd_vld_o
);
    localparam int unsigned CW    = jsd_pkg::jsd_cw(KD);
    localparam int unsigned RATIO = jsd_pkg::jsd_gcd(KM, KD);

    // R7: configuration checks at elaboration
    if (RATIO != 1) begin : g_bad_ratio
        $error("jitter_decimator: KM and KD share a common factor");
    end
    if (KD < 2) begin : g_bad_kd
        $error("jitter_decimator: KD must be at least 2");
    end
    if (GUARD_STAGES < 1) begin : g_bad_guard
        $error("jitter_decimator: at least one guard stage is required");
    end

    logic          smp;
    logic          wrap;
    logic [CW-1:0] cnt;

    jsd_sampler #(.GUARD_STAGES(GUARD_STAGES)) u_smp (
        .clk   (clk_smp_i),
        .rst   (rst_i),
        .jit_i (jit_clk_i),
        .smp_o (smp)
    );

    jsd_window_ctr #(.KD(KD)) u_ctr (
        .clk    (clk_smp_i),
        .rst    (rst_i),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    jsd_parity_acc u_acc (
        .clk    (clk_smp_i),
        .rst    (rst_i),
        .smp_i  (smp),
        .wrap_i (wrap),
        .bit_o  (rnd_bit_o),
        .vld_o  (rnd_vld_o)
    );

    // R2
    win_align_chk: assert property (@(posedge clk_smp_i) disable iff (rst_i)
        rnd_vld_o |-> (cnt == '0));

endmodule

// File: tb/tb_jitter_decimator.sv
module tb_jitter_decimator;
    localparam int unsigned KM  = 5;
    localparam int unsigned KD  = 7;
    localparam int unsigned GS  = 1;
    localparam int unsigned LAT = 1 + GS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic jit = 1'b0;
    logic rbit;
    logic rvld;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    jitter_decimator #(.KM(KM), .KD(KD), .GUARD_STAGES(GS)) dut (
        .clk_smp_i (clk_smp_i_w),
        .rst_i     (rst),
        .jit_clk_i (jit),
        .rnd_bit_o (rbit),
        .rnd_vld_o (rvld)
    );
    wire clk_smp_i_w = clk;

    // Jitter-free level of the jittered clock at sample n.
    function automatic bit lvl(int unsigned n);
        return ((2 * n * KM) % (2 * KD)) < KD;
    endfunction

    // Flipped windows: even w in 2..2KD, position (w-2)/2 in the window.
    function automatic bit flip_at(int unsigned k);
        for (int unsigned w = 2; w <= 2 * KD; w += 2) begin
            if (k == w * KD - LAT + (w - 2) / 2) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic bit pat_parity();
        bit p = 1'b0;
        for (int unsigned n = 0; n < KD; n++) p ^= lvl(n);
        return p;
    endfunction

    function automatic bit expect_bit(int unsigned w, bit jit_on);
        bit p = 1'b0;
        if (w == 0) begin
            for (int unsigned n = 0; n + LAT < KD; n++) p ^= lvl(n);
            return p;
        end
        p = pat_parity();
        if (jit_on && (w % 2 == 0) && w >= 2 && w <= 2 * KD) p = ~p;
        return p;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        jit = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(rvld == 1'b0, "R1 vld in reset", rvld, 0);
        chk(rbit == 1'b0, "R1 bit in reset", rbit, 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Entered at a negedge with reset low; sample k meets posedge k.
    task automatic run_windows(int unsigned nw, bit jit_on);
        logic last_bit = 1'b0;
        for (int unsigned k = 0; k < nw * KD; k++) begin
            jit = lvl(k) ^ (jit_on & flip_at(k));
            @(posedge clk);
            #1;
            if (k == 0) begin
                chk(rvld == 1'b0 && rbit == 1'b0, "R1 first cycle", {rvld, rbit}, 0);
            end
            if (k % KD == KD - 1) begin
                int unsigned w = k / KD;
                bit e = expect_bit(w, jit_on);
                chk(rvld == 1'b1, "R2 strobe at window end", rvld, 1);
                if (w == 0)
                    chk(rbit == e, "R3 first window parity", rbit, e);
                else if (jit_on && e != pat_parity())
                    chk(rbit == e, "R5 flipped window", rbit, e);
                else if (jit_on)
                    chk(rbit == e, "R6 neighbour window clean", rbit, e);
                else
                    chk(rbit == e, "R4 constant parity", rbit, e);
                last_bit = rbit;
            end else begin
                chk(rvld == 1'b0, "R2 no strobe mid window", rvld, 0);
                if (k >= KD) chk(rbit == last_bit, "R8 bit held", rbit, last_bit);
            end
            @(negedge clk);
        end
    endtask

    initial begin
        chk(jsd_pkg::jsd_gcd(KM, KD) == 1 && KD >= 2, "R7 coprime config",
            int'(jsd_pkg::jsd_gcd(KM, KD)), 1);
        do_reset();
        run_windows(6, 1'b0);
        do_reset();
        run_windows(2 * KD + 4, 1'b1);
        do_reset();
        run_windows(3, 1'b0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule